// File: doc/BRIEF.md
# Sideways ROM Bank Mapper

This block sits between a host CPU's sideways ROM window (&8000 to &BFFF) and a 1 MB external RAM organised as 64 blocks of 16 KB. It takes the 4-bit ROM select value, which names one of 16 slots, and produces the six upper RAM address bits. It also tells the board whether the current window access goes to RAM or to the slot's physical ROM socket. Each slot holds a 3-bit type code. The host loads that code by writing to a spare location in the &FE3x I/O page.

The type code puts a slot into one of four modes, which act as the block's states. MODE_EXT routes the slot to its ROM socket. MODE_SWRAM gives plain sideways RAM. MODE_PAGE32 emulates a 32 KB paged ROM with two pages. MODE_PAGE128 emulates a 128 KB paged ROM with eight pages.

A host write to the configuration location moves a slot from any mode to any other mode, and clears that slot's page. In the paged modes, a CPU read of a trigger address moves the slot's page register to a new page. Each slot keeps its own page. A single shared decode path serves all slots: the ROM select value chooses the active slot's type and page, and the lookup adds a page offset to the slot's base block.

Top module: `swrom_bank_mapper`

## Requirements
- R1: After reset, every slot is in external ROM mode with page 0, so a window read asserts ext_rom_en whatever rom_sel is.
- R2: A write (cpu_wr high at a clock edge) to address &FE3E with data bit 3 clear loads data[2:0] into the type register of slot data[7:4]. A write to any other address, or a write with data bit 3 set, changes no type register.
- R3: Type code 0 and the unused codes 4 to 7 select external ROM mode. A window access then asserts ext_rom_en, and ram_block reads 0.
- R4: Type code 1 maps the slot to RAM block number equal to the slot number.
- R5: Type code 2 (32 KB paged) maps page 0 to block slot and page 1 to block slot+12. A read of &BFE0 selects page 0, and a read of &BFE4 selects page 1.
- R6: Type code 3 (128 KB paged) maps page p to block slot+12p when p<4, and to block slot+34+2p when p>=4, modulo 64. A read of any address from &BFF8 to &BFFF selects page addr[2:0].
- R7: A trigger read is itself served from the old page. The new block appears from the next clock cycle.
- R8: Triggers act only on reads with addr[15:14]=2'b10 while the slot is selected, and only for trigger addresses of that slot's own type. Writes, idle cycles, reads outside the window and reads of the other type's triggers leave the page unchanged. The page registers of other slots are never affected.
- R9: Writing a slot's type register clears that slot's page to 0, even when the code written is the same as before.
- R10: A window access is cpu_rd or cpu_wr high with addr[15:14]=2'b10. During a window access, exactly one of ram_ce and ext_rom_en is high. At all other times both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read cycle qualifier |
| cpu_wr | input | 1 | CPU write cycle qualifier |
| rom_sel | input | 4 | Current sideways slot number |
| ram_block | output | 6 | Upper RAM address (16 KB block number) |
| ram_ce | output | 1 | RAM enable for the window access |
| ext_rom_en | output | 1 | Physical ROM socket enable for the window access |

## Verification
The assertions take for granted that rom_sel, cpu_addr, cpu_rd and cpu_wr stay steady around each rising edge and that cpu_rd and cpu_wr are never high together. Under those conditions the combinational outputs seen at an edge belong to one well-defined bus cycle. The stimulus changes every input only on the falling edge, asserts at most one strobe per cycle, and holds each vector for one full cycle. The bench compares the outputs just before the rising edge that commits any register update.

// File: rtl/swmap_pkg.sv
package swmap_pkg;

    localparam int TYPE_W     = 3;
    localparam int PAGE_W     = 3;
    localparam int CPU_AW     = 16;
    localparam int CPU_DW     = 8;
    localparam int PAGE_STEP  = 12;   // block distance between low pages
    localparam int HIGH_OFF   = 34;   // offset for pages 4..7: slot + 34 + 2p

    typedef enum logic [1:0] {
        MODE_EXT,
        MODE_SWRAM,
        MODE_PAGE32,
        MODE_PAGE128
    } slot_mode_e;

    function automatic slot_mode_e mode_of(input logic [TYPE_W-1:0] code);
        case (code)
            3'd1:    return MODE_SWRAM;
            3'd2:    return MODE_PAGE32;
            3'd3:    return MODE_PAGE128;
            default: return MODE_EXT;
        endcase
    endfunction

endpackage

// File: rtl/swmap_cfg_regs.sv
module swmap_cfg_regs
    import swmap_pkg::*;
#(
    parameter int          SLOTS    = 16,
    parameter logic [15:0] CFG_ADDR = 16'hFE3E
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CPU_AW-1:0]        cpu_addr,
    input  logic [CPU_DW-1:0]        cpu_data,
    input  logic                     cpu_wr,
    output logic [SLOTS*TYPE_W-1:0]  type_flat,
    output logic [SLOTS-1:0]         type_wr_hit
);
    localparam int SEL_W = $clog2(SLOTS);

    logic cfg_wr;
    assign cfg_wr = cpu_wr && (cpu_addr == CFG_ADDR) && !cpu_data[3];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [TYPE_W-1:0] type_q;

        assign type_wr_hit[s] = cfg_wr && (cpu_data[4 +: SEL_W] == SEL_W'(s));

        always_ff @(posedge clk) begin
            if (!rst_n)
                type_q <= '0;
            else if (type_wr_hit[s])
                type_q <= cpu_data[TYPE_W-1:0];
        end

        assign type_flat[s*TYPE_W +: TYPE_W] = type_q;
    end

endmodule

// File: rtl/swmap_page_regs.sv
module swmap_page_regs
    import swmap_pkg::*;
#(
    parameter int SLOTS = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SLOTS-1:0]           clr,
    input  logic                       upd_en,
    input  logic [$clog2(SLOTS)-1:0]   upd_slot,
    input  logic [PAGE_W-1:0]          upd_page,
    output logic [SLOTS*PAGE_W-1:0]    page_flat
);
    localparam int SEL_W = $clog2(SLOTS);

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [PAGE_W-1:0] page_q;

        always_ff @(posedge clk) begin
            if (!rst_n)
                page_q <= '0;
            else if (clr[s])
                page_q <= '0;
            else if (upd_en && (upd_slot == SEL_W'(s)))
                page_q <= upd_page;
        end

        assign page_flat[s*PAGE_W +: PAGE_W] = page_q;
    end

endmodule

// File: rtl/swmap_decode.sv
module swmap_decode
    import swmap_pkg::*;
#(
    parameter int SLOTS   = 16,
    parameter int BLOCK_W = 6
) (
    input  logic [$clog2(SLOTS)-1:0] slot,
    input  logic [TYPE_W-1:0]        type_code,
    input  logic [PAGE_W-1:0]        page,
    input  logic [CPU_AW-1:0]        cpu_addr,
    input  logic                     cpu_rd,
    input  logic                     cpu_wr,
    output logic [BLOCK_W-1:0]       ram_block,
    output logic                     ram_ce,
    output logic                     ext_rom_en,
    output logic                     trig_en,
    output logic [PAGE_W-1:0]        trig_page
);
    localparam logic [CPU_AW-1:0] TRIG32_P0 = 16'hBFE0;
    localparam logic [CPU_AW-1:0] TRIG32_P1 = 16'hBFE4;
    localparam logic [CPU_AW-1:0] TRIG128   = 16'hBFF8;

    slot_mode_e         mode;
    logic               in_window;
    logic               win_access;
    logic               win_read;
    logic [BLOCK_W-1:0] base;
    logic [BLOCK_W-1:0] low_off;
    logic [BLOCK_W-1:0] high_off;

    assign mode       = mode_of(type_code);
    assign in_window  = (cpu_addr[15:14] == 2'b10);
    assign win_access = in_window && (cpu_rd || cpu_wr);
    assign win_read   = in_window && cpu_rd;
    assign base       = BLOCK_W'(slot);
    assign low_off    = BLOCK_W'(PAGE_STEP) * BLOCK_W'(page[1:0]);
    assign high_off   = BLOCK_W'(HIGH_OFF) + BLOCK_W'({page, 1'b0});

    always_comb begin
        ram_block  = '0;
        ram_ce     = 1'b0;
        ext_rom_en = 1'b0;
        trig_en    = 1'b0;
        trig_page  = '0;
        unique case (mode)
            MODE_EXT: begin
                ext_rom_en = win_access;
            end
            MODE_SWRAM: begin
                ram_block = base;
                ram_ce    = win_access;
            end
            MODE_PAGE32: begin
                ram_block = page[0] ? base + BLOCK_W'(PAGE_STEP) : base;
                ram_ce    = win_access;
                if (win_read && (cpu_addr == TRIG32_P0)) begin
                    trig_en   = 1'b1;
                    trig_page = '0;
                end else if (win_read && (cpu_addr == TRIG32_P1)) begin
                    trig_en   = 1'b1;
                    trig_page = PAGE_W'(1);
                end
            end
            MODE_PAGE128: begin
                ram_block = page[2] ? base + high_off : base + low_off;
                ram_ce    = win_access;
                if (win_read && (cpu_addr[CPU_AW-1:3] == TRIG128[CPU_AW-1:3])) begin
                    trig_en   = 1'b1;
                    trig_page = cpu_addr[2:0];
                end
            end
        endcase
    end

endmodule

// File: rtl/swrom_bank_mapper.sv
module swrom_bank_mapper
    import swmap_pkg::*;
#(
    parameter int          SLOTS    = 16,
    parameter int          BLOCK_W  = 6,
    parameter logic [15:0] CFG_ADDR = 16'hFE3E
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [15:0]        cpu_addr,
    input  logic [7:0]         cpu_data,
    input  logic               cpu_rd,
    input  logic               cpu_wr,
    input  logic [3:0]         rom_sel,
    output logic [BLOCK_W-1:0] ram_block,
    output logic               ram_ce,
    output logic               ext_rom_en
);
    localparam int SEL_W = $clog2(SLOTS);

    logic [SLOTS*TYPE_W-1:0] type_flat;
    logic [SLOTS-1:0]        type_wr_hit;
    logic [SLOTS*PAGE_W-1:0] page_flat;
    logic [SEL_W-1:0]        slot;
    logic [TYPE_W-1:0]       act_type;
    logic [PAGE_W-1:0]       act_page;
    logic                    trig_en;
    logic [PAGE_W-1:0]       trig_page;

    assign slot     = rom_sel[SEL_W-1:0];
    assign act_type = type_flat[slot*TYPE_W +: TYPE_W];
    assign act_page = page_flat[slot*PAGE_W +: PAGE_W];

    swmap_cfg_regs #(.SLOTS(SLOTS), .CFG_ADDR(CFG_ADDR)) cfg_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_addr    (cpu_addr),
        .cpu_data    (cpu_data),
        .cpu_wr      (cpu_wr),
        .type_flat   (type_flat),
        .type_wr_hit (type_wr_hit)
    );

    swmap_page_regs #(.SLOTS(SLOTS)) page_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (type_wr_hit),
        .upd_en    (trig_en),
        .upd_slot  (slot),
        .upd_page  (trig_page),
        .page_flat (page_flat)
    );

    swmap_decode #(.SLOTS(SLOTS), .BLOCK_W(BLOCK_W)) dec_i (
        .slot       (slot),
        .type_code  (act_type),
        .page       (act_page),
        .cpu_addr   (cpu_addr),
        .cpu_rd     (cpu_rd),
        .cpu_wr     (cpu_wr),
        .ram_block  (ram_block),
        .ram_ce     (ram_ce),
        .ext_rom_en (ext_rom_en),
        .trig_en    (trig_en),
        .trig_page  (trig_page)
    );

endmodule

// File: rtl/swmap_chk.sv
module swmap_chk #(
    parameter int          BLOCK_W  = 6,
    parameter logic [15:0] CFG_ADDR = 16'hFE3E
) (
    input logic               clk,
    input logic               rst_n,
    input logic [15:0]        cpu_addr,
    input logic               cpu_rd,
    input logic               cpu_wr,
    input logic [3:0]         rom_sel,
    input logic [BLOCK_W-1:0] ram_block,
    input logic               ram_ce,
    input logic               ext_rom_en
);
    logic win_acc;
    assign win_acc = (cpu_addr[15:14] == 2'b10) && (cpu_rd || cpu_wr);

    // R10
    enables_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_ce && ext_rom_en));

    // R10
    window_one_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_acc |-> (ram_ce != ext_rom_en));

    // R10
    idle_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_acc |-> (!ram_ce && !ext_rom_en));

    // R3
    ext_block_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rom_en |-> (ram_block == '0));

    // R8
    no_trigger_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rd && !(cpu_wr && cpu_addr == CFG_ADDR))
        |=> ((rom_sel != $past(rom_sel)) || $stable(ram_block)));

endmodule

bind swrom_bank_mapper swmap_chk #(.BLOCK_W(BLOCK_W), .CFG_ADDR(CFG_ADDR)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .cpu_rd     (cpu_rd),
    .cpu_wr     (cpu_wr),
    .rom_sel    (rom_sel),
    .ram_block  (ram_block),
    .ram_ce     (ram_ce),
    .ext_rom_en (ext_rom_en)
);

// File: tb/swrom_bank_mapper_tb_top.sv
module swrom_bank_mapper_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 52;

    typedef struct packed {
        logic [3:0]  sel;
        logic [15:0] addr;
        logic        rd;
        logic        wr;
        logic [7:0]  data;
        logic [5:0]  blk;
        logic        ce;
        logic        ext;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [0:NV-1] = '{
        '{4'd3,  16'h8000, 1'b1, 1'b0, 8'h00, 6'd0,  1'b0, 1'b1, 4'd1},  // R1
        '{4'd3,  16'hFE3E, 1'b0, 1'b1, 8'h31, 6'd0,  1'b0, 1'b0, 4'd2},  // R2
        '{4'd3,  16'h9000, 1'b1, 1'b0, 8'h00, 6'd3,  1'b1, 1'b0, 4'd4},  // R4
        '{4'd4,  16'hFE3D, 1'b0, 1'b1, 8'h41, 6'd0,  1'b0, 1'b0, 4'd2},  // R2 wrong address
        '{4'd4,  16'hFE3E, 1'b0, 1'b1, 8'h49, 6'd0,  1'b0, 1'b0, 4'd2},  // R2 bit 3 set
        '{4'd4,  16'h8000, 1'b1, 1'b0, 8'h00, 6'd0,  1'b0, 1'b1, 4'd2},  // R2 slot 4 unchanged
        '{4'd10, 16'hFE3E, 1'b0, 1'b1, 8'hA2, 6'd0,  1'b0, 1'b0, 4'd2},  // R2
        '{4'd10, 16'h8123, 1'b1, 1'b0, 8'h00, 6'd10, 1'b1, 1'b0, 4'd5},  // R5
        '{4'd10, 16'hBFE4, 1'b1, 1'b0, 8'h00, 6'd10, 1'b1, 1'b0, 4'd7},  // R7
        '{4'd10, 16'h8000, 1'b1, 1'b0, 8'h00, 6'd22, 1'b1, 1'b0, 4'd5},  // R5
        '{4'd10, 16'hBFE0, 1'b1, 1'b0, 8'h00, 6'd22, 1'b1, 1'b0, 4'd7},  // R7
        '{4'd10, 16'hA000, 1'b1, 1'b0, 8'h00, 6'd10, 1'b1, 1'b0, 4'd5},  // R5
        '{4'd10, 16'h3FE4, 1'b1, 1'b0, 8'h00, 6'd10, 1'b0, 1'b0, 4'd8},  // R8 outside window
        '{4'd10, 16'h8000, 1'b1, 1'b0, 8'h00, 6'd10, 1'b1, 1'b0, 4'd8},  // R8
        '{4'd10, 16'hBFE4, 1'b0, 1'b1, 8'h00, 6'd10, 1'b1, 1'b0, 4'd8},  // R8 write no trigger
        '{4'd10, 16'h8000, 1'b1, 1'b0, 8'h00, 6'd10, 1'b1, 1'b0, 4'd8},  // R8
        '{4'd10, 16'hBFFF, 1'b1, 1'b0, 8'h00, 6'd10, 1'b1, 1'b0, 4'd8},  // R8 foreign trigger
        '{4'd10, 16'h8000, 1'b1, 1'b0, 8'h00, 6'd10, 1'b1, 1'b0, 4'd8},  // R8
        '{4'd10, 16'hBFE4, 1'b1, 1'b0, 8'h00, 6'd10, 1'b1, 1'b0, 4'd5},  // R5
        '{4'd10, 16'hFE3E, 1'b0, 1'b1, 8'h83, 6'd22, 1'b0, 1'b0, 4'd2},  // R2 slot 8 type 3
        '{4'd8,  16'hBFFD, 1'b1, 1'b0, 8'h00, 6'd8,  1'b1, 1'b0, 4'd6},  // R6
        '{4'd8,  16'h8000, 1'b1, 1'b0, 8'h00, 6'd52, 1'b1, 1'b0, 4'd6},  // R6 page 5
        '{4'd8,  16'hBFFB, 1'b1, 1'b0, 8'h00, 6'd52, 1'b1, 1'b0, 4'd7},  // R7
        '{4'd8,  16'h8000, 1'b1, 1'b0, 8'h00, 6'd44, 1'b1, 1'b0, 4'd6},  // R6 page 3
        '{4'd10, 16'h8000, 1'b1, 1'b0, 8'h00, 6'd22, 1'b1, 1'b0, 4'd8},  // R8 slot 10 kept
        '{4'd10, 16'hBFE0, 1'b1, 1'b0, 8'h00, 6'd22, 1'b1, 1'b0, 4'd5},  // R5
        '{4'd8,  16'h8000, 1'b1, 1'b0, 8'h00, 6'd44, 1'b1, 1'b0, 4'd8},  // R8 slot 8 kept
        '{4'd8,  16'hBFFF, 1'b0, 1'b0, 8'h00, 6'd44, 1'b0, 1'b0, 4'd10}, // R10 idle
        '{4'd8,  16'h8000, 1'b1, 1'b0, 8'h00, 6'd44, 1'b1, 1'b0, 4'd8},  // R8
        '{4'd8,  16'hBFFF, 1'b1, 1'b0, 8'h00, 6'd44, 1'b1, 1'b0, 4'd6},  // R6
        '{4'd8,  16'h8000, 1'b1, 1'b0, 8'h00, 6'd56, 1'b1, 1'b0, 4'd6},  // R6 page 7
        '{4'd8,  16'hBFE4, 1'b1, 1'b0, 8'h00, 6'd56, 1'b1, 1'b0, 4'd8},  // R8 foreign trigger
        '{4'd8,  16'h8000, 1'b1, 1'b0, 8'h00, 6'd56, 1'b1, 1'b0, 4'd8},  // R8
        '{4'd8,  16'hFE3E, 1'b0, 1'b1, 8'h83, 6'd56, 1'b0, 1'b0, 4'd9},  // R9
        '{4'd8,  16'h8000, 1'b1, 1'b0, 8'h00, 6'd8,  1'b1, 1'b0, 4'd9},  // R9
        '{4'd10, 16'hBFE4, 1'b1, 1'b0, 8'h00, 6'd10, 1'b1, 1'b0, 4'd5},  // R5
        '{4'd10, 16'hFE3E, 1'b0, 1'b1, 8'hA2, 6'd22, 1'b0, 1'b0, 4'd9},  // R9
        '{4'd10, 16'h8000, 1'b1, 1'b0, 8'h00, 6'd10, 1'b1, 1'b0, 4'd9},  // R9
        '{4'd5,  16'hFE3E, 1'b0, 1'b1, 8'h56, 6'd0,  1'b0, 1'b0, 4'd3},  // R3 unused code 6
        '{4'd5,  16'h8000, 1'b1, 1'b0, 8'h00, 6'd0,  1'b0, 1'b1, 4'd3},  // R3
        '{4'd5,  16'hBFFF, 1'b0, 1'b1, 8'h00, 6'd0,  1'b0, 1'b1, 4'd3},  // R3 write
        '{4'd3,  16'hFE3E, 1'b0, 1'b1, 8'h30, 6'd3,  1'b0, 1'b0, 4'd3},  // R3 back to code 0
        '{4'd3,  16'hA000, 1'b1, 1'b0, 8'h00, 6'd0,  1'b0, 1'b1, 4'd3},  // R3
        '{4'd15, 16'hFE3E, 1'b0, 1'b1, 8'hF1, 6'd0,  1'b0, 1'b0, 4'd4},  // R4
        '{4'd15, 16'hBFFF, 1'b1, 1'b0, 8'h00, 6'd15, 1'b1, 1'b0, 4'd4},  // R4
        '{4'd15, 16'hC000, 1'b1, 1'b0, 8'h00, 6'd15, 1'b0, 1'b0, 4'd10}, // R10 above window
        '{4'd15, 16'hFE3E, 1'b0, 1'b1, 8'hF3, 6'd15, 1'b0, 1'b0, 4'd6},  // R6
        '{4'd15, 16'hBFFF, 1'b1, 1'b0, 8'h00, 6'd15, 1'b1, 1'b0, 4'd6},  // R6
        '{4'd15, 16'hBFFB, 1'b1, 1'b0, 8'h00, 6'd63, 1'b1, 1'b0, 4'd6},  // R6 page 7 -> 63
        '{4'd15, 16'h8000, 1'b1, 1'b0, 8'h00, 6'd51, 1'b1, 1'b0, 4'd6},  // R6 page 3 -> 51
        '{4'd15, 16'hBFF8, 1'b1, 1'b0, 8'h00, 6'd51, 1'b1, 1'b0, 4'd6},  // R6
        '{4'd15, 16'h8000, 1'b1, 1'b0, 8'h00, 6'd15, 1'b1, 1'b0, 4'd6}   // R6 page 0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [3:0]  rom_sel = '0;
    logic [5:0]  ram_block;
    logic        ram_ce;
    logic        ext_rom_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swrom_bank_mapper dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_addr   (cpu_addr),
        .cpu_data   (cpu_data),
        .cpu_rd     (cpu_rd),
        .cpu_wr     (cpu_wr),
        .rom_sel    (rom_sel),
        .ram_block  (ram_block),
        .ram_ce     (ram_ce),
        .ext_rom_en (ext_rom_en)
    );

    task automatic drive(input logic [3:0] s, input logic [15:0] a,
                         input logic r, input logic w, input logic [7:0] d);
        @(negedge clk);
        rom_sel  = s;
        cpu_addr = a;
        cpu_rd   = r;
        cpu_wr   = w;
        cpu_data = d;
        #1;
    endtask

    task automatic expect_out(input string tag, input logic [5:0] blk,
                              input logic ce, input logic ext);
        checks++;
        if (ram_block !== blk || ram_ce !== ce || ext_rom_en !== ext) begin
            errors++;
            $display("FAIL %s: got block=%0d ce=%0b ext=%0b expected block=%0d ce=%0b ext=%0b",
                     tag, ram_block, ram_ce, ext_rom_en, blk, ce, ext);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].sel, VECS[i].addr, VECS[i].rd, VECS[i].wr, VECS[i].data);
            expect_out($sformatf("R%0d vector %0d", VECS[i].req, i),
                       VECS[i].blk, VECS[i].ce, VECS[i].ext);
        end

        // R1: set slot 8 to a paged mode on a high page, then reset mid-run
        drive(4'd8, 16'hFE3E, 1'b0, 1'b1, 8'h83);
        drive(4'd8, 16'hBFFE, 1'b1, 1'b0, 8'h00);
        drive(4'd8, 16'h8000, 1'b1, 1'b0, 8'h00);
        expect_out("R6 setup page 6", 6'd54, 1'b1, 1'b0);
        rst_n = 1'b0;
        drive(4'd8, 16'h8000, 1'b0, 1'b0, 8'h00);
        drive(4'd8, 16'h8000, 1'b0, 1'b0, 8'h00);
        rst_n = 1'b1;
        drive(4'd8, 16'h8000, 1'b1, 1'b0, 8'h00);
        expect_out("R1 slot 8 external after reset", 6'd0, 1'b0, 1'b1);
        drive(4'd15, 16'hA000, 1'b1, 1'b0, 8'h00);
        expect_out("R1 slot 15 external after reset", 6'd0, 1'b0, 1'b1);
        // R1: page register back at 0 after reset
        drive(4'd8, 16'hFE3E, 1'b0, 1'b1, 8'h83);
        drive(4'd8, 16'h8000, 1'b1, 1'b0, 8'h00);
        expect_out("R1 slot 8 page 0 after reset", 6'd8, 1'b1, 1'b0);

        drive(4'd0, 16'h0000, 1'b0, 1'b0, 8'h00);
        finish_run();
    end

endmodule